// File: doc/BRIEF.md
# Cascadable LCD Column Row Loader

This block is the digital core of a dot-matrix LCD column driver with 80 segment outputs. Display data arrives four bits at a time. A nibble is taken on each falling edge of a shift clock, but only while the chip holds the enable token. The shift clock and the latch pulse are sampled by the system clock, and the block acts on their falling edges. Once the row holds all twenty nibbles, the block asserts its enable output. This hands the token to the next driver in a cascade, and any further shift clocks leave the row alone.

A direction input does two things. It picks which of the two enable pins is the input and which is the output. It also picks whether the row fills from the top segment downward or from segment 0 upward. A falling latch pulse copies the row into an output latch and returns the token. Each segment then gets a 2-bit drive-level code, chosen from its latched bit, the frame (AC polarity) input and a forced-blank input.

Top module: `seg_row_loader`

## Requirements
- R1: After synchronous reset the output latch is all zero, and both enable outputs read 1 (released). With frame high and blank inactive, every segment code is 01.
- R2: A nibble is captured when the system clock sees a falling edge on `shclk_i` while the chip is enabled. Twenty captures fill the 80-bit row.
- R3: With `dir_i`=1, the k-th captured nibble (k from 0) places `din_i[3]`, `din_i[2]`, `din_i[1]` and `din_i[0]` on segments 79-4k, 78-4k, 77-4k and 76-4k.
- R4: With `dir_i`=0, the k-th captured nibble places `din_i[3]`, `din_i[2]`, `din_i[1]` and `din_i[0]` on segments 4k, 4k+1, 4k+2 and 4k+3.
- R5: With `dir_i`=1, pin A is the enable input and pin B is the output (`en_b_oe_o`=1, `en_a_oe_o`=0). With `dir_i`=0 the roles swap. Exactly one output-enable flag is high at any time.
- R6: The active-low enable output goes to 0 at the twentieth capture. It returns to 1 at the next latch falling edge.
- R7: Shift falling edges leave the row unchanged in two cases: when the row is already full, and when the chip is not armed and its enable input is 1.
- R8: Segment codes change only at a latch falling edge, whatever data is being shifted in.
- R9: Segment code 00 is V0, 01 is V2, 10 is V3 and 11 is V5. With frame high, a lit bit gives 11 and an unlit bit gives 01. With frame low, a lit bit gives 00 and an unlit bit gives 10.
- R10: While `blank_n_i` is 0, every segment code is 00.
- R11: The first capture arms the chip. It keeps capturing through the rest of the row even if the enable input returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shclk_i | input | 1 | Shift clock; acts on its falling edge |
| latch_i | input | 1 | Latch pulse; acts on its falling edge |
| din_i | input | 4 | Display data nibble |
| dir_i | input | 1 | Direction and enable-pin role select |
| en_a_i | input | 1 | Enable pin A, input side (active low) |
| en_a_o | output | 1 | Enable pin A, output value (active low) |
| en_a_oe_o | output | 1 | Enable pin A drives when 1 |
| en_b_i | input | 1 | Enable pin B, input side (active low) |
| en_b_o | output | 1 | Enable pin B, output value (active low) |
| en_b_oe_o | output | 1 | Enable pin B drives when 1 |
| frame_i | input | 1 | Frame / AC polarity |
| blank_n_i | input | 1 | Forced blank, active low |
| seg_lvl_o | output | 160 | Two-bit level code per segment; segment s uses bits [2s+1:2s] |

## Verification
The assertions rely on a few input conditions:
- Data and the enable input are stable in the system-clock cycle where a shift falling edge is seen.
- The shift and latch strobes each stay high and low for at least one system clock.
- A latch edge never lands in the same cycle as a shift edge.
- The direction input changes only between rows.

The stimulus drives every input on the falling system-clock edge. It holds each strobe level for a full cycle, and it changes direction only right after a latch pulse, so every assumption is met.

// File: rtl/seg_row_pkg.sv
package seg_row_pkg;

    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } lvl_e;

    // Drive-level choice for one segment from its latched bit.
    function automatic lvl_e pick_level(input logic lit, input logic frame,
                                        input logic blank_n);
        lvl_e v;
        if (!blank_n)   v = LVL_V0;
        else if (frame) v = lit ? LVL_V5 : LVL_V2;
        else            v = lit ? LVL_V0 : LVL_V3;
        return v;
    endfunction

endpackage

// File: rtl/seg_row_edge.sv
module seg_row_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/seg_row_fill.sv
module seg_row_fill #(
    parameter int NUM_SEG = 80,
    parameter int BUS_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_fall_i,
    input  logic               latch_fall_i,
    input  logic [BUS_W-1:0]   din_i,
    input  logic               dir_i,
    input  logic               en_in_n_i,
    output logic [NUM_SEG-1:0] row_o,
    output logic               done_o
);
    localparam int NIBBLES = NUM_SEG / BUS_W;
    localparam int CNT_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NIBBLES - 1);

    typedef struct packed {
        logic [NUM_SEG-1:0] row;
        logic [CNT_W-1:0]   cnt;
        logic               armed;
        logic               done;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic [BUS_W-1:0] din_rev;
    logic [CNT_W-1:0] slot;
    logic             take;

    // Bit-reversed nibble for the upward fill order.
    generate
        for (genvar b = 0; b < BUS_W; b++) begin : g_rev
            assign din_rev[b] = din_i[BUS_W-1-b];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        take = shift_fall_i && !st_q.done && (st_q.armed || !en_in_n_i);
        slot = dir_i ? (LAST - st_q.cnt) : st_q.cnt;
        if (take) begin
            for (int s = 0; s < NIBBLES; s++) begin
                if (CNT_W'(s) == slot)
                    st_d.row[s*BUS_W +: BUS_W] = dir_i ? din_i : din_rev;
            end
            if (st_q.cnt == LAST) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
                st_d.armed = 1'b1;
            end
        end
        if (latch_fall_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
            st_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign row_o  = st_q.row;
    assign done_o = st_q.done;

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);
    assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.done |=> $stable(st_q.row));
    assert_done_on_last_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.done) |-> $past(st_q.cnt) == LAST);
endmodule

// File: rtl/seg_row_outsel.sv
module seg_row_outsel
    import seg_row_pkg::*;
#(
    parameter int NUM_SEG = 80
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 latch_fall_i,
    input  logic [NUM_SEG-1:0]   row_i,
    input  logic                 frame_i,
    input  logic                 blank_n_i,
    output logic [2*NUM_SEG-1:0] lvl_o
);
    logic [NUM_SEG-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (latch_fall_i) lat_d = row_i;
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    generate
        for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
            assign lvl_o[2*s +: 2] = pick_level(lat_q[s], frame_i, blank_n_i);
        end
    endgenerate

    assert_latch_only_R8: assert property (@(posedge clk) disable iff (rst)
        !latch_fall_i |=> $stable(lat_q));
    assert_blank_v0_R10: assert property (@(posedge clk) disable iff (rst)
        !blank_n_i |-> lvl_o == '0);
endmodule

// File: rtl/seg_row_loader.sv
module seg_row_loader
    import seg_row_pkg::*;
#(
    parameter int NUM_SEG = 80,
    parameter int BUS_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shclk_i,
    input  logic                 latch_i,
    input  logic [BUS_W-1:0]     din_i,
    input  logic                 dir_i,
    input  logic                 en_a_i,
    output logic                 en_a_o,
    output logic                 en_a_oe_o,
    input  logic                 en_b_i,
    output logic                 en_b_o,
    output logic                 en_b_oe_o,
    input  logic                 frame_i,
    input  logic                 blank_n_i,
    output logic [2*NUM_SEG-1:0] seg_lvl_o
);
    logic               shift_fall, latch_fall, done, en_in_n;
    logic [NUM_SEG-1:0] row;

    seg_row_edge u_shift_edge (.clk(clk), .rst(rst), .sig_i(shclk_i), .fall_o(shift_fall));
    seg_row_edge u_latch_edge (.clk(clk), .rst(rst), .sig_i(latch_i), .fall_o(latch_fall));

    // Direction picks which pin listens and which one passes the token on.
    assign en_in_n   = dir_i ? en_a_i : en_b_i;
    assign en_a_oe_o = ~dir_i;
    assign en_b_oe_o = dir_i;
    assign en_a_o    = dir_i ? 1'b1 : ~done;
    assign en_b_o    = dir_i ? ~done : 1'b1;

    seg_row_fill #(.NUM_SEG(NUM_SEG), .BUS_W(BUS_W)) u_fill (
        .clk(clk), .rst(rst), .shift_fall_i(shift_fall), .latch_fall_i(latch_fall),
        .din_i(din_i), .dir_i(dir_i), .en_in_n_i(en_in_n),
        .row_o(row), .done_o(done)
    );

    seg_row_outsel #(.NUM_SEG(NUM_SEG)) u_out (
        .clk(clk), .rst(rst), .latch_fall_i(latch_fall), .row_i(row),
        .frame_i(frame_i), .blank_n_i(blank_n_i), .lvl_o(seg_lvl_o)
    );

    assert_one_driver_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot({en_a_oe_o, en_b_oe_o}));
endmodule

// File: tb/sim_seg_row_loader.sv
module sim_seg_row_loader;
    localparam int NS = 80;
    localparam int NN = NS / 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shclk = 1'b0, latch = 1'b0, dir = 1'b1;
    logic [3:0] din = '0;
    logic en_a_i = 1'b1, en_b_i = 1'b1, frame = 1'b1, blank_n = 1'b1;
    logic en_a_o, en_a_oe, en_b_o, en_b_oe;
    logic [2*NS-1:0] lvl;

    int checks = 0, fails = 0;
    bit exp_lat [NS];
    bit pend [NS];
    int taken = 0;

    always #4 clk = ~clk;

    seg_row_loader u0 (
        .clk(clk), .rst(rst), .shclk_i(shclk), .latch_i(latch), .din_i(din),
        .dir_i(dir), .en_a_i(en_a_i), .en_a_o(en_a_o), .en_a_oe_o(en_a_oe),
        .en_b_i(en_b_i), .en_b_o(en_b_o), .en_b_oe_o(en_b_oe),
        .frame_i(frame), .blank_n_i(blank_n), .seg_lvl_o(lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare every segment code against the bench's latched row.
    task automatic chk_levels(input string req);
        int bad = -1, a = 0, e = 0;
        for (int s = 0; s < NS; s++) begin
            int ev;
            if (!blank_n) ev = 0;
            else if (frame) ev = exp_lat[s] ? 3 : 1;
            else ev = exp_lat[s] ? 0 : 2;
            if (bad < 0 && int'(lvl[2*s +: 2]) != ev) begin
                bad = s; a = int'(lvl[2*s +: 2]); e = ev;
            end
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: segment %0d actual %0d expected %0d", req, bad, a, e);
        end
    endtask

    task automatic shift(input logic [3:0] n, input bit takes);
        @(negedge clk); din = n; shclk = 1'b1;
        @(negedge clk); shclk = 1'b0;
        @(negedge clk);
        if (takes) begin
            for (int j = 0; j < 4; j++) begin
                int seg = dir ? (NS - 1 - (4*taken + j)) : (4*taken + j);
                pend[seg] = n[3-j];
            end
            taken++;
        end
    endtask

    task automatic pulse_latch();
        @(negedge clk); latch = 1'b1;
        @(negedge clk); latch = 1'b0;
        @(negedge clk);
        for (int s = 0; s < NS; s++) exp_lat[s] = pend[s];
        taken = 0;
    endtask

    task automatic set_in(input logic v);
        if (dir) en_a_i = v; else en_b_i = v;
    endtask

    function automatic logic out_pin();
        return dir ? en_b_o : en_a_o;
    endfunction

    task automatic run_row(input logic d, input int seed);
        string ord = d ? "R3" : "R4";
        dir = d; en_a_i = 1'b1; en_b_i = 1'b1;
        @(negedge clk);
        chk("R5 b_oe", int'(en_b_oe), int'(d));
        chk("R5 a_oe", int'(en_a_oe), int'(!d));
        shift(4'hA, 0);
        shift(4'h5, 0);
        set_in(1'b0);
        shift(4'((seed * 5 + 1) & 15), 1);
        set_in(1'b1);                              // R11: stays armed
        for (int k = 1; k < NN; k++) begin
            if (k == NN - 1) chk("R6 out before last", int'(out_pin()), 1);
            shift(4'((seed * 5 + k * 3 + 1) & 15), 1);
        end
        chk("R6 out after last", int'(out_pin()), 0);
        frame = 1'b1; blank_n = 1'b1;
        chk_levels("R8 hold before latch");
        shift(4'hF, 0);                            // R7: row full
        shift(4'h0, 0);
        pulse_latch();
        chk("R6 released by latch", int'(out_pin()), 1);
        chk_levels({ord, "/R11/R2/R7 frame high"});
        frame = 1'b0; @(negedge clk);
        chk_levels("R9 frame low");
        blank_n = 1'b0; @(negedge clk);
        chk_levels("R10 blank frame low");
        frame = 1'b1; @(negedge clk);
        chk_levels("R10 blank frame high");
        blank_n = 1'b1; @(negedge clk);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin exp_lat[s] = 0; pend[s] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_levels("R1 reset levels");
        chk("R1 en_a_o", int'(en_a_o), 1);
        chk("R1 en_b_o", int'(en_b_o), 1);
        for (int seed = 0; seed < 4; seed++) begin
            run_row(1'b1, seed);
            run_row(1'b0, seed + 7);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule